// File: doc/BRIEF.md
# Sticky Status Flags with Maskable Interrupt

This block gathers the health monitors of a clock generator into a small byte-wide register window. The monitors are calibration busy, crystal-input signal loss, selected-reference signal loss, PLL unlock, serial-bus timeout, and signal loss on each clock input. The block does not detect any of these faults itself. It receives them as synchronous level inputs and registers each one into a read-only live status bit.

Each live bit has its own sticky flag. The flag latches the first assertion of its monitor and holds it until software writes a zero to that flag position. Writing a one to a flag position has no effect. Each flag also has a mask bit. An active-low interrupt output is driven low while at least one flag is set and not masked. Software releases the interrupt either by clearing the flags that are set or by masking them.

Top module: `stflag_top`

## Requirements
- R1: Address 0x0C reads the live core status one clock after the monitors change. Bit 0 is calibration busy, bit 1 is crystal-input loss, bit 2 is selected-reference loss, bit 3 is PLL unlock and bit 5 is bus timeout. Writes to this address have no effect.
- R2: Address 0x0D reads the live clock-input loss bits one clock after the inputs change. Bit 0 is input 0, bit 1 is input 1, bit 2 is input 2 and bit 3 is the feedback input. Writes to this address have no effect.
- R3: Addresses 0x11 (core) and 0x12 (clock inputs) hold sticky flags in the same bit positions as the live bytes. A flag becomes 1 one clock after its monitor is high, and it stays 1 after the monitor drops.
- R4: Writing 0 to a flag bit clears it at the next clock edge. Writing 1 to a flag bit leaves it unchanged.
- R5: If a monitor is high in the same cycle that its flag is written with 0, the flag stays set.
- R6: Addresses 0x17 (core) and 0x18 (clock inputs) hold mask bits in the same positions as the flags. A write takes effect at the next clock edge and reads back.
- R7: `irq_n` is 0 exactly when some flag is 1 and its mask bit is 0. It is evaluated from the current flag and mask registers. It returns to 1 once every set flag has been cleared or masked.
- R8: These bits always read 0 and ignore writes: core bit 4, core bits 7:6, and bits 7:4 of the clock-input bytes. Any unmapped address reads 0x00.
- R9: While `rst` is high and after it is released, all live bits, flags and masks are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_cal_busy | input | 1 | Calibration in progress |
| mon_xtal_los | input | 1 | Crystal-input signal loss |
| mon_ref_los | input | 1 | Selected-reference signal loss |
| mon_pll_unlock | input | 1 | PLL loss of lock |
| mon_bus_tmo | input | 1 | Serial-bus timeout |
| mon_clkin_los | input | N_CLKIN | Clock-input signal loss, feedback input at the top bit |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench drives the inputs with several kinds of pattern:
- Single-cycle monitor pulses, which separate the live bits, which follow the monitor, from the sticky flags, which must hold.
- Zero writes while a monitor stays high, which expose a wrong priority between setting and clearing.
- Writes of ones and writes to read-only or unmapped addresses, which show whether unused bits and live bytes can be disturbed.

It then runs mask-then-clear and clear-then-mask orders, followed by a long random mix. Together these show whether the interrupt follows the flag and mask registers with no extra or missing cycle.

// File: rtl/stflag_pkg.sv
package stflag_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t ADR_LIVE_CORE = 8'h0C;
    localparam byte_t ADR_LIVE_CLK  = 8'h0D;
    localparam byte_t ADR_FLAG_CORE = 8'h11;
    localparam byte_t ADR_FLAG_CLK  = 8'h12;
    localparam byte_t ADR_MASK_CORE = 8'h17;
    localparam byte_t ADR_MASK_CLK  = 8'h18;

    // Implemented positions of the core byte: bits 0..3 and 5
    localparam byte_t CORE_VALID = 8'h2F;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LIVE_CORE,
        SEL_LIVE_CLK,
        SEL_FLAG_CORE,
        SEL_FLAG_CLK,
        SEL_MASK_CORE,
        SEL_MASK_CLK
    } reg_sel_e;

    typedef struct packed {
        logic cal_busy;
        logic xtal_los;
        logic ref_los;
        logic pll_unlock;
        logic bus_tmo;
    } core_mon_t;

    typedef struct packed {
        byte_t live;
        byte_t flag;
        byte_t mask;
        logic  pend;
    } grp_view_t;

    function automatic byte_t clkin_valid(input int n);
        byte_t v;
        v = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (i < n) v[i] = 1'b1;
        end
        return v;
    endfunction

    function automatic byte_t pack_core(input core_mon_t m);
        byte_t b;
        b    = '0;
        b[0] = m.cal_busy;
        b[1] = m.xtal_los;
        b[2] = m.ref_los;
        b[3] = m.pll_unlock;
        b[5] = m.bus_tmo;
        return b;
    endfunction

    function automatic reg_sel_e decode_addr(input byte_t a);
        case (a)
            ADR_LIVE_CORE: return SEL_LIVE_CORE;
            ADR_LIVE_CLK:  return SEL_LIVE_CLK;
            ADR_FLAG_CORE: return SEL_FLAG_CORE;
            ADR_FLAG_CLK:  return SEL_FLAG_CLK;
            ADR_MASK_CORE: return SEL_MASK_CORE;
            ADR_MASK_CLK:  return SEL_MASK_CLK;
            default:       return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/stflag_cell.sv
module stflag_cell (
    input  logic clk,
    input  logic rst,
    input  logic mon_i,
    input  logic clr_i,
    input  logic mask_we_i,
    input  logic mask_d_i,
    output logic live_o,
    output logic flag_o,
    output logic mask_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            live_o <= 1'b0;
            flag_o <= 1'b0;
            mask_o <= 1'b0;
        end else begin
            live_o <= mon_i;
            // a live event outranks a clear in the same cycle
            flag_o <= mon_i | (flag_o & ~clr_i);
            if (mask_we_i) mask_o <= mask_d_i;
        end
    end
endmodule

// File: rtl/stflag_group.sv
module stflag_group
    import stflag_pkg::*;
#(
    parameter byte_t VALID = 8'hFF
) (
    input  logic      clk,
    input  logic      rst,
    input  byte_t     mon_i,
    input  logic      flag_wr_i,
    input  logic      mask_wr_i,
    input  byte_t     wdata_i,
    output grp_view_t view_o
);
    byte_t live_w, flag_w, mask_w;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        if (VALID[b]) begin : g_cell
            stflag_cell u_cell (
                .clk       (clk),
                .rst       (rst),
                .mon_i     (mon_i[b]),
                .clr_i     (flag_wr_i & ~wdata_i[b]),
                .mask_we_i (mask_wr_i),
                .mask_d_i  (wdata_i[b]),
                .live_o    (live_w[b]),
                .flag_o    (flag_w[b]),
                .mask_o    (mask_w[b])
            );
        end else begin : g_hole
            assign live_w[b] = 1'b0;
            assign flag_w[b] = 1'b0;
            assign mask_w[b] = 1'b0;
        end
    end

    assign view_o.live = live_w;
    assign view_o.flag = flag_w;
    assign view_o.mask = mask_w;
    assign view_o.pend = |(flag_w & ~mask_w);

    AST_LIVE_LAT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (live_w == ($past(mon_i) & VALID)));  // R1
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(flag_w) & ~($past(flag_wr_i) ? ~$past(wdata_i) : 8'h00)) & ~flag_w) == 8'h00));  // R3
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
        flag_wr_i |=> ((~$past(wdata_i) & ~$past(mon_i) & flag_w) == 8'h00));  // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(mon_i) & VALID & ~flag_w) == 8'h00));  // R5
    AST_MASK_WR: assert property (@(posedge clk) disable iff (rst)
        mask_wr_i |=> (mask_w == ($past(wdata_i) & VALID)));  // R6
endmodule

// File: rtl/stflag_decode.sv
module stflag_decode
    import stflag_pkg::*;
(
    input  logic       wr_en_i,
    input  byte_t      addr_i,
    output reg_sel_e   sel_o,
    output logic [1:0] flag_wr_o,
    output logic [1:0] mask_wr_o
);
    always_comb begin
        sel_o     = decode_addr(addr_i);
        flag_wr_o = 2'b00;
        mask_wr_o = 2'b00;
        if (wr_en_i) begin
            case (sel_o)
                SEL_FLAG_CORE: flag_wr_o[0] = 1'b1;
                SEL_FLAG_CLK:  flag_wr_o[1] = 1'b1;
                SEL_MASK_CORE: mask_wr_o[0] = 1'b1;
                SEL_MASK_CLK:  mask_wr_o[1] = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/stflag_top.sv
module stflag_top
    import stflag_pkg::*;
#(
    parameter int N_CLKIN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mon_cal_busy,
    input  logic               mon_xtal_los,
    input  logic               mon_ref_los,
    input  logic               mon_pll_unlock,
    input  logic               mon_bus_tmo,
    input  logic [N_CLKIN-1:0] mon_clkin_los,
    input  logic               cfg_wr_en,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [BYTE_W-1:0]  cfg_wdata,
    output logic [BYTE_W-1:0]  cfg_rdata,
    output logic               irq_n
);
    localparam byte_t CLK_VALID = clkin_valid(N_CLKIN);

    core_mon_t  core_mon;
    byte_t      core_byte, clk_byte;
    reg_sel_e   sel;
    logic [1:0] flag_wr, mask_wr;
    grp_view_t  v_core, v_clk;
    byte_t      rd_valid;

    assign core_mon  = '{cal_busy:   mon_cal_busy,
                         xtal_los:   mon_xtal_los,
                         ref_los:    mon_ref_los,
                         pll_unlock: mon_pll_unlock,
                         bus_tmo:    mon_bus_tmo};
    assign core_byte = pack_core(core_mon);
    assign clk_byte  = byte_t'(mon_clkin_los);

    stflag_decode u_dec (
        .wr_en_i   (cfg_wr_en),
        .addr_i    (cfg_addr),
        .sel_o     (sel),
        .flag_wr_o (flag_wr),
        .mask_wr_o (mask_wr)
    );

    stflag_group #(.VALID(CORE_VALID)) u_core (
        .clk       (clk),
        .rst       (rst),
        .mon_i     (core_byte),
        .flag_wr_i (flag_wr[0]),
        .mask_wr_i (mask_wr[0]),
        .wdata_i   (cfg_wdata),
        .view_o    (v_core)
    );

    stflag_group #(.VALID(CLK_VALID)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .mon_i     (clk_byte),
        .flag_wr_i (flag_wr[1]),
        .mask_wr_i (mask_wr[1]),
        .wdata_i   (cfg_wdata),
        .view_o    (v_clk)
    );

    always_comb begin
        case (sel)
            SEL_LIVE_CORE: begin cfg_rdata = v_core.live; rd_valid = CORE_VALID; end
            SEL_LIVE_CLK:  begin cfg_rdata = v_clk.live;  rd_valid = CLK_VALID;  end
            SEL_FLAG_CORE: begin cfg_rdata = v_core.flag; rd_valid = CORE_VALID; end
            SEL_FLAG_CLK:  begin cfg_rdata = v_clk.flag;  rd_valid = CLK_VALID;  end
            SEL_MASK_CORE: begin cfg_rdata = v_core.mask; rd_valid = CORE_VALID; end
            SEL_MASK_CLK:  begin cfg_rdata = v_clk.mask;  rd_valid = CLK_VALID;  end
            default:       begin cfg_rdata = 8'h00;       rd_valid = 8'h00;      end
        endcase
    end

    assign irq_n = ~(v_core.pend | v_clk.pend);

    AST_IRQ_AFTER_RST: assert property (@(posedge clk)
        rst |=> irq_n);  // R9
    AST_RD_UNUSED: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & ~rd_valid) == 8'h00);  // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> ((v_core.flag | v_clk.flag) != 8'h00));  // R7
endmodule

// File: tb/stflag_top_bench.sv
module stflag_top_bench;
    localparam int N_CLKIN = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       m_cal, m_xtal, m_ref, m_lol, m_tmo;
    logic [3:0] m_in;
    logic       wr_en;
    logic [7:0] addr, wdata, rdata;
    logic       irq_n;

    always #2.5 clk = ~clk;

    stflag_top #(.N_CLKIN(N_CLKIN)) u_stflag_top (
        .clk(clk), .rst(rst),
        .mon_cal_busy(m_cal), .mon_xtal_los(m_xtal), .mon_ref_los(m_ref),
        .mon_pll_unlock(m_lol), .mon_bus_tmo(m_tmo), .mon_clkin_los(m_in),
        .cfg_wr_en(wr_en), .cfg_addr(addr), .cfg_wdata(wdata),
        .cfg_rdata(rdata), .irq_n(irq_n)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // behavioural reference state
    logic [7:0] r_live[2], r_flag[2], r_mask[2];
    logic [7:0] vmask[2];

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'h0C: return r_live[0];
            8'h0D: return r_live[1];
            8'h11: return r_flag[0];
            8'h12: return r_flag[1];
            8'h17: return r_mask[0];
            8'h18: return r_mask[1];
            default: return 8'h00;
        endcase
    endfunction

    // one clock: core monitor byte uses bits 0,1,2,3,5 per R1
    task automatic step(input logic r, input logic [7:0] core, input logic [3:0] cin,
                        input logic w, input logic [7:0] a, input logic [7:0] d,
                        input string req);
        logic [7:0] mon[2];
        logic [7:0] clr;
        logic       eirq;
        @(negedge clk);
        rst = r;
        m_cal = core[0]; m_xtal = core[1]; m_ref = core[2]; m_lol = core[3]; m_tmo = core[5];
        m_in = cin; wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        mon[0] = core & vmask[0];
        mon[1] = {4'h0, cin} & vmask[1];
        for (int g = 0; g < 2; g++) begin
            if (r) begin
                r_live[g] = 0; r_flag[g] = 0; r_mask[g] = 0;
            end else begin
                clr = (w && a == (g == 0 ? 8'h11 : 8'h12)) ? (~d & vmask[g]) : 8'h00;
                r_live[g] = mon[g];
                r_flag[g] = (r_flag[g] & ~clr) | mon[g];
                if (w && a == (g == 0 ? 8'h17 : 8'h18)) r_mask[g] = d & vmask[g];
            end
        end
        #1;
        eirq = !(((r_flag[0] & ~r_mask[0]) | (r_flag[1] & ~r_mask[1])) != 0);
        tests++;
        if (rdata !== exp_read(a)) begin
            fails++;
            $display("FAIL %s rdata addr=%02h actual=%02h expected=%02h", req, a, rdata, exp_read(a));
        end
        tests++;
        if (irq_n !== eirq) begin
            fails++;
            $display("FAIL %s irq_n actual=%b expected=%b", req, irq_n, eirq);
        end
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        step(1'b0, 8'h00, 4'h0, 1'b0, a, 8'h00, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        vmask[0] = 8'h2F; vmask[1] = 8'h0F;
        r_live[0] = 0; r_live[1] = 0; r_flag[0] = 0; r_flag[1] = 0; r_mask[0] = 0; r_mask[1] = 0;
        rst = 1; m_cal = 0; m_xtal = 0; m_ref = 0; m_lol = 0; m_tmo = 0; m_in = 0;
        wr_en = 0; addr = 0; wdata = 0;

        // R9: reset holds everything clear, even with monitors active
        step(1'b1, 8'h2F, 4'hF, 1'b1, 8'h17, 8'hFF, "R9");
        step(1'b1, 8'h00, 4'h0, 1'b0, 8'h11, 8'h00, "R9");
        foreach (vmask[g]) begin
            rd(g == 0 ? 8'h0C : 8'h0D, "R9");
            rd(g == 0 ? 8'h11 : 8'h12, "R9");
            rd(g == 0 ? 8'h17 : 8'h18, "R9");
        end

        // R1: one-cycle pulse on each core monitor, live byte follows
        for (int b = 0; b < 8; b++) begin
            step(1'b0, 8'(1 << b), 4'h0, 1'b0, 8'h0C, 8'h00, "R1");
            rd(8'h0C, "R1");
            rd(8'h11, "R3");
        end
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h0C, 8'hFF, "R1");
        // R4: writing ones leaves flags, then zeros clear
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h11, 8'hFF, "R4");
        rd(8'h11, "R4");
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h11, 8'hFE, "R4");
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h11, 8'h00, "R4");
        rd(8'h11, "R4");

        // R2: clock-input pulses, feedback at bit 3
        for (int b = 0; b < 4; b++) begin
            step(1'b0, 8'h00, 4'(1 << b), 1'b0, 8'h0D, 8'h00, "R2");
            rd(8'h0D, "R2");
            rd(8'h12, "R3");
        end
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h0D, 8'hFF, "R2");

        // R5: clear while monitor still high keeps flag
        step(1'b0, 8'h00, 4'h4, 1'b1, 8'h12, 8'h00, "R5");
        rd(8'h12, "R5");
        step(1'b0, 8'h08, 4'h0, 1'b0, 8'h11, 8'h00, "R5");
        step(1'b0, 8'h08, 4'h0, 1'b1, 8'h11, 8'h00, "R5");
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h11, 8'h00, "R5");
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h12, 8'h00, "R5");

        // R6/R7: mask releases interrupt, unmask reasserts, clear releases
        step(1'b0, 8'h20, 4'h2, 1'b0, 8'h11, 8'h00, "R7");
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h17, 8'h20, "R6");
        rd(8'h17, "R6");
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h18, 8'h02, "R7");
        rd(8'h18, "R6");
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h17, 8'h00, "R7");
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h11, 8'hDF, "R7");
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h18, 8'h00, "R7");
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h12, 8'h00, "R7");

        // R8: unused bits and unmapped addresses
        step(1'b0, 8'hFF, 4'hF, 1'b1, 8'h17, 8'hFF, "R8");
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h18, 8'hFF, "R8");
        rd(8'h17, "R8");
        rd(8'h18, "R8");
        rd(8'h11, "R8");
        rd(8'h12, "R8");
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h20, 8'hFF, "R8");
        rd(8'h13, "R8");
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h17, 8'h00, "R8");
        step(1'b0, 8'h00, 4'h0, 1'b1, 8'h18, 8'h00, "R8");

        // random mix across all requirements
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] c, a, d;
            logic [3:0] n;
            logic w;
            c = 8'($urandom) & 8'($urandom) & 8'($urandom);
            n = 4'($urandom) & 4'($urandom) & 4'($urandom);
            w = ($urandom % 3) == 0;
            case ($urandom % 8)
                0: a = 8'h0C; 1: a = 8'h0D; 2: a = 8'h11; 3: a = 8'h12;
                4: a = 8'h17; 5: a = 8'h18; 6: a = 8'h11; default: a = 8'($urandom);
            endcase
            d = 8'($urandom);
            step(($urandom % 500) == 0, c, n, w, a, d, "R7");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule